// File: doc/BRIEF.md
# Block-Mode Bus Transaction Master

This block runs one transaction at a time on an 8-byte-wide block-mode I/O bus for a local requester. The requester presents a descriptor made of a command, a start address and a byte count. A bad byte count is turned away at once. A good descriptor is latched, the block raises a one-cycle bus request, and it then waits for the arbiter's one-cycle grant.

After the grant, the block drives one header beat that packs the command, the byte count and the address. A write or a scrub then streams the data beats from the local write port under a valid/ready handshake. A read or a test-and-set sends only the header. Every transaction closes with a one-cycle terminate, and the block is idle again on the cycle after that. Each byte lane of the bus carries its own odd-parity bit.

Top module: `blkbus_master`

## Requirements
- R1: After a synchronous active-high reset the block is idle: `cmd_ready` is 1, and `bus_req`, `bus_valid`, `bus_term`, `wr_ready` and `busy` are 0.
- R2: A descriptor offered while idle with a byte count of 0 or above 64 raises `cmd_reject` in the same cycle. No bus request follows, and the block stays idle.
- R3: A descriptor accepted while idle (byte count 1 to 64) makes `bus_req` high for exactly the next cycle.
- R4: After the request the block waits with no bus activity for as many cycles as the grant takes. The header beat appears in the cycle after `bus_gnt` is sampled high.
- R5: The header beat places the command code in bits 63:56, the byte count in bits 55:48, zero in bits 47:40 and the address in bits 39:0. Command codes are read 0, write 1, scrub 2, test-and-set 3.
- R6: A write (code 1) or a scrub (code 2) follows the header with ceil(byte count / 8) data beats. Each beat passes `wr_data` to `bus_data` with `bus_valid` in a cycle where `wr_valid` and `wr_ready` are both high. A cycle with `wr_valid` low sends nothing and consumes no beat.
- R7: A read (code 0) or a test-and-set (code 3) sends only the header beat. The cycle after the header is the terminate.
- R8: `bus_term` is high for exactly one cycle after the last beat. In the cycle after it, `cmd_ready` is 1 and `busy` is 0.
- R9: On every cycle, each byte lane of `bus_data` together with its bit of `bus_par` has an odd number of ones.
- R10: `cmd_ready` is high only while idle. A descriptor offered while busy is ignored: it causes no reject and does not change the transaction in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Descriptor offered |
| cmd_op | input | 2 | Command code: 0 read, 1 write, 2 scrub, 3 test-and-set |
| cmd_addr | input | 40 | Start address |
| cmd_bytes | input | 8 | Byte count, legal 1 to 64 |
| cmd_ready | output | 1 | Block idle and able to take a descriptor |
| cmd_reject | output | 1 | Offered descriptor has an illegal byte count |
| wr_valid | input | 1 | Write data beat available |
| wr_data | input | 64 | Write data beat |
| wr_ready | output | 1 | Block is taking data beats |
| bus_req | output | 1 | One-cycle bus request |
| bus_gnt | input | 1 | One-cycle bus grant |
| bus_valid | output | 1 | Header or data beat on the bus |
| bus_data | output | 64 | Bus beat (zero when no beat) |
| bus_par | output | 8 | Odd parity, one bit per byte lane |
| bus_term | output | 1 | One-cycle terminate |
| busy | output | 1 | Transaction in progress |

## Verification
The assertions check the properties that hold cycle by cycle: odd parity on every lane, the one-cycle width of the request and the terminate, a quiet bus while idle, the coupling of the write handshake to `bus_valid`, and that a reject never leads to a request. The following can only be shown by the bench's scenarios, each of which knows which descriptor it sent:
- the exact header bit layout,
- the beat count that the byte count rounds up to, including the 1-byte and 64-byte ends,
- header-only framing for reads and test-and-set,
- indefinite waiting for a late grant,
- descriptors ignored in mid-flight.

// File: rtl/bm_pkg.sv
package bm_pkg;

    localparam int BM_DATA_W    = 64;
    localparam int BM_LANES     = BM_DATA_W / 8;
    localparam int BM_ADDR_W    = 40;
    localparam int BM_CNT_W     = 8;
    localparam int BM_MAX_BYTES = 64;
    localparam int BM_MAX_BEATS = BM_MAX_BYTES / BM_LANES;
    localparam int BM_BEAT_W    = $clog2(BM_MAX_BEATS + 1);

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SCRUB = 2'd2,
        OP_TAS   = 2'd3
    } bm_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT_GNT,
        ST_HEADER,
        ST_DATA,
        ST_TERM
    } bm_state_e;

    typedef struct packed {
        bm_op_e                op;
        logic [BM_CNT_W-1:0]   bytes;
        logic [BM_ADDR_W-1:0]  addr;
    } bm_desc_t;

    function automatic logic bm_bytes_ok(input logic [BM_CNT_W-1:0] n);
        return (n != '0) && (int'(n) <= BM_MAX_BYTES);
    endfunction

    function automatic logic [BM_BEAT_W-1:0] bm_beats(input logic [BM_CNT_W-1:0] n);
        logic [BM_CNT_W:0] sum;
        sum = {1'b0, n} + (BM_CNT_W+1)'(BM_LANES - 1);
        return BM_BEAT_W'(sum >> $clog2(BM_LANES));
    endfunction

    function automatic logic bm_carries_data(input bm_op_e op);
        return (op == OP_WRITE) || (op == OP_SCRUB);
    endfunction

    function automatic logic [BM_DATA_W-1:0] bm_header(input bm_desc_t d);
        logic [BM_DATA_W-1:0] h;
        h = '0;
        h[63:56] = {6'b0, d.op};
        h[55:48] = d.bytes;
        h[BM_ADDR_W-1:0] = d.addr;
        return h;
    endfunction

endpackage

// File: rtl/bm_desc_check.sv
module bm_desc_check
    import bm_pkg::*;
(
    input  bm_op_e                op_i,
    input  logic [BM_CNT_W-1:0]   bytes_i,
    output logic                  ok_o,
    output logic [BM_BEAT_W-1:0]  beats_o,
    output logic                  has_data_o
);
    always_comb begin
        ok_o       = bm_bytes_ok(bytes_i);
        beats_o    = bm_beats(bytes_i);
        has_data_o = bm_carries_data(op_i);
    end
endmodule

// File: rtl/bm_lane_parity.sv
module bm_lane_parity #(
    parameter int LANES = 8
) (
    input  logic [LANES*8-1:0] data_i,
    output logic [LANES-1:0]   par_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign par_o[g] = ~(^data_i[g*8 +: 8]);
    end
endmodule

// File: rtl/bm_seq.sv
module bm_seq
    import bm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid_i,
    input  logic                  desc_ok_i,
    input  logic                  has_data_i,
    input  logic [BM_BEAT_W-1:0]  beats_i,
    input  logic                  gnt_i,
    input  logic                  wr_valid_i,
    output bm_state_e             state_o,
    output logic                  load_o,
    output logic                  reject_o
);
    bm_state_e             state_q;
    logic [BM_BEAT_W-1:0]  cnt_q;
    logic                  last_beat;

    assign last_beat = (cnt_q == beats_i - BM_BEAT_W'(1));
    assign load_o    = (state_q == ST_IDLE) && cmd_valid_i && desc_ok_i;
    assign reject_o  = (state_q == ST_IDLE) && cmd_valid_i && !desc_ok_i;
    assign state_o   = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE:     if (load_o) state_q <= ST_REQ;
                ST_REQ:      state_q <= ST_WAIT_GNT;
                ST_WAIT_GNT: if (gnt_i) state_q <= ST_HEADER;
                ST_HEADER: begin
                    cnt_q   <= '0;
                    state_q <= has_data_i ? ST_DATA : ST_TERM;
                end
                ST_DATA: begin
                    if (wr_valid_i) begin
                        cnt_q <= cnt_q + BM_BEAT_W'(1);
                        if (last_beat) state_q <= ST_TERM;
                    end
                end
                ST_TERM:     state_q <= ST_IDLE;
                default:     state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/blkbus_master.sv
module blkbus_master
    import bm_pkg::*;
#(
    parameter int DATA_W = BM_DATA_W,
    parameter int ADDR_W = BM_ADDR_W,
    parameter int CNT_W  = BM_CNT_W,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_bytes,
    output logic              cmd_ready,
    output logic              cmd_reject,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic [DATA_W-1:0] bus_data,
    output logic [LANES-1:0]  bus_par,
    output logic              bus_term,
    output logic              busy
);
    bm_op_e                in_op;
    logic                  desc_ok;
    logic [BM_BEAT_W-1:0]  desc_beats;
    logic                  desc_has_data;
    bm_desc_t              desc_q;
    logic [BM_BEAT_W-1:0]  beats_q;
    logic                  has_data_q;
    bm_state_e             state;
    logic                  load;

    assign in_op = bm_op_e'(cmd_op);

    bm_desc_check u_desc (
        .op_i       (in_op),
        .bytes_i    (cmd_bytes),
        .ok_o       (desc_ok),
        .beats_o    (desc_beats),
        .has_data_o (desc_has_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            desc_q     <= '0;
            beats_q    <= '0;
            has_data_q <= 1'b0;
        end else if (load) begin
            desc_q     <= '{op: in_op, bytes: cmd_bytes, addr: cmd_addr};
            beats_q    <= desc_beats;
            has_data_q <= desc_has_data;
        end
    end

    bm_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid_i (cmd_valid),
        .desc_ok_i   (desc_ok),
        .has_data_i  (has_data_q),
        .beats_i     (beats_q),
        .gnt_i       (bus_gnt),
        .wr_valid_i  (wr_valid),
        .state_o     (state),
        .load_o      (load),
        .reject_o    (cmd_reject)
    );

    always_comb begin
        cmd_ready = (state == ST_IDLE);
        busy      = (state != ST_IDLE);
        bus_req   = (state == ST_REQ);
        bus_term  = (state == ST_TERM);
        wr_ready  = (state == ST_DATA);
        bus_valid = 1'b0;
        bus_data  = '0;
        if (state == ST_HEADER) begin
            bus_valid = 1'b1;
            bus_data  = bm_header(desc_q);
        end else if (state == ST_DATA && wr_valid) begin
            bus_valid = 1'b1;
            bus_data  = wr_data;
        end
    end

    bm_lane_parity #(.LANES(LANES)) u_par (
        .data_i (bus_data),
        .par_o  (bus_par)
    );
endmodule

// File: rtl/bm_master_chk.sv
module bm_master_chk
    import bm_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  cmd_ready,
    input logic                  cmd_reject,
    input logic                  wr_valid,
    input logic                  wr_ready,
    input logic                  bus_req,
    input logic                  bus_valid,
    input logic [BM_DATA_W-1:0]  bus_data,
    input logic [BM_LANES-1:0]   bus_par,
    input logic                  bus_term,
    input logic                  busy
);
    logic all_odd;
    always_comb begin
        all_odd = 1'b1;
        for (int i = 0; i < BM_LANES; i++) begin
            if ($countones({bus_data[i*8 +: 8], bus_par[i]}) % 2 != 1) all_odd = 1'b0;
        end
    end

    // R2
    reject_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_reject |=> (!bus_req && !busy));

    // R3
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> (!bus_req && busy));

    // R6
    wr_link_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> ((bus_valid == wr_valid) && !bus_term && !bus_req));

    // R8
    term_release_chk: assert property (@(posedge clk) disable iff (rst)
        bus_term |=> (!bus_term && cmd_ready && !busy));

    // R9
    lane_parity_chk: assert property (@(posedge clk) disable iff (rst)
        all_odd);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (!bus_valid && !bus_term && !bus_req && !wr_ready && !busy));
endmodule

bind blkbus_master bm_master_chk u_bm_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_ready  (cmd_ready),
    .cmd_reject (cmd_reject),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .bus_req    (bus_req),
    .bus_valid  (bus_valid),
    .bus_data   (bus_data),
    .bus_par    (bus_par),
    .bus_term   (bus_term),
    .busy       (busy)
);

// File: tb/blkbus_master_tb.sv
module blkbus_master_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [39:0] cmd_addr;
    logic [7:0]  cmd_bytes;
    logic        cmd_ready, cmd_reject;
    logic        wr_valid;
    logic [63:0] wr_data;
    logic        wr_ready, bus_req, bus_gnt, bus_valid, bus_term, busy;
    logic [63:0] bus_data;
    logic [7:0]  bus_par;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    blkbus_master dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_bytes(cmd_bytes), .cmd_ready(cmd_ready),
        .cmd_reject(cmd_reject), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_valid(bus_valid), .bus_data(bus_data), .bus_par(bus_par),
        .bus_term(bus_term), .busy(busy)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] odd_par(input logic [63:0] d);
        logic [7:0] p;
        for (int i = 0; i < 8; i++) p[i] = ~(^d[i*8 +: 8]);
        return p;
    endfunction

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    task automatic t_reset();
        rst = 1'b1; cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_bytes = 0;
        wr_valid = 0; wr_data = 0; bus_gnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        check(cmd_ready && !bus_req && !bus_valid && !bus_term && !wr_ready && !busy, "R1",
              {58'b0, cmd_ready, bus_req, bus_valid, bus_term, wr_ready, busy}, 64'h20);
    endtask

    task automatic t_reject(input logic [7:0] n);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 2'd1; cmd_addr = 40'h12345; cmd_bytes = n;
        #2;
        check(cmd_reject == 1'b1, "R2 reject", {63'b0, cmd_reject}, 64'h1);
        @(negedge clk);
        cmd_valid = 0;
        #2;
        check(!bus_req && !busy && cmd_ready, "R2 stays idle", {61'b0, bus_req, busy, cmd_ready}, 64'h1);
    endtask

    task automatic t_xfer(input logic [1:0] op, input logic [7:0] n, input logic [39:0] a,
                          input int gnt_delay, input bit stall);
        logic [63:0] hdr;
        int nbeats;
        bit data_op;
        hdr = {6'b0, op, n, 8'h00, a};
        nbeats = (int'(n) + 7) / 8;
        data_op = (op == 2'd1) || (op == 2'd2);

        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_bytes = n;
        #2;
        check(cmd_ready && !cmd_reject, "R10 ready when idle", {62'b0, cmd_ready, cmd_reject}, 64'h2);
        @(negedge clk);
        cmd_valid = 0;
        #2;
        check(bus_req == 1'b1, "R3 request", {63'b0, bus_req}, 64'h1);

        // descriptor offered while waiting must be ignored
        @(negedge clk);
        cmd_valid = 1; cmd_op = ~op; cmd_addr = ~a; cmd_bytes = 8'd0;
        #2;
        check(!bus_req && !cmd_reject && !cmd_ready && busy, "R10 ignored while busy",
              {60'b0, bus_req, cmd_reject, cmd_ready, busy}, 64'h1);
        @(negedge clk);
        cmd_valid = 0;
        for (int i = 0; i < gnt_delay; i++) begin
            @(negedge clk);
            #2;
            check(!bus_valid && !bus_term && busy, "R4 waiting for grant",
                  {61'b0, bus_valid, bus_term, busy}, 64'h1);
        end
        @(negedge clk);
        bus_gnt = 1;
        @(negedge clk);
        bus_gnt = 0;
        #2;
        check(bus_valid == 1'b1, "R4 header after grant", {63'b0, bus_valid}, 64'h1);
        check(bus_data == hdr, "R5 header layout", bus_data, hdr);
        check(bus_par == odd_par(hdr), "R9 header parity", {56'b0, bus_par}, {56'b0, odd_par(hdr)});

        if (data_op) begin
            for (int b = 0; b < nbeats; b++) begin
                logic [63:0] pat;
                pat = {a[31:0], 24'h0, 8'(b)} ^ 64'hA5C3_0F96_1234_8E71;
                if (stall && b == 1) begin
                    @(negedge clk);
                    wr_valid = 0;
                    #2;
                    check(wr_ready && !bus_valid && !bus_term, "R6 stall sends nothing",
                          {61'b0, wr_ready, bus_valid, bus_term}, 64'h4);
                end
                @(negedge clk);
                wr_valid = 1; wr_data = pat;
                #2;
                check(wr_ready && bus_valid && bus_data == pat, "R6 data beat", bus_data, pat);
                check(bus_par == odd_par(pat), "R9 data parity", {56'b0, bus_par}, {56'b0, odd_par(pat)});
            end
        end
        @(negedge clk);
        wr_valid = 0;
        #2;
        check(bus_term && !bus_valid && !wr_ready, data_op ? "R8 terminate after last beat" : "R7 header-only terminate",
              {61'b0, bus_term, bus_valid, wr_ready}, 64'h4);
        step();
        check(!bus_term && cmd_ready && !busy, "R8 back to idle",
              {61'b0, bus_term, cmd_ready, busy}, 64'h2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_reject(8'd0);
        t_reject(8'd65);
        t_reject(8'd200);
        t_xfer(2'd1, 8'd20, 40'hAB_0000_1000, 0, 1'b1);
        t_xfer(2'd1, 8'd64, 40'h00_FFFF_FFF8, 3, 1'b0);
        t_xfer(2'd2, 8'd1,  40'h7F_1234_5670, 1, 1'b0);
        t_xfer(2'd2, 8'd9,  40'h01_0000_0040, 0, 1'b1);
        t_xfer(2'd0, 8'd64, 40'h33_4444_5550, 2, 1'b0);
        t_xfer(2'd3, 8'd8,  40'hFF_FFFF_FFFF, 5, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule